// File: doc/BRIEF.md
# Square-Root Carry-Select Adder

This block is a purely combinational unsigned adder. It takes two operands and a carry-in, and it returns their sum together with a carry-out. The operand is cut into 16-bit slices. Inside each slice the bits are split into five groups of growing width: 2, 2, 3, 4 and 5 bits. The lowest group is a plain ripple adder fed by the carry-in. Every group above it forms two candidate results at once, one for an incoming carry of zero and one for an incoming carry of one. A multiplexer then picks between them using the carry chosen by the group below.

Two styles can be chosen for the carry-one candidate. The first uses an incrementer, often called an excess-one converter, applied to the carry-zero result with its carry bit included. The second uses a second ripple adder whose carry-in is tied high. Both styles are meant to give exactly the same answer, so they can be compared directly. Wider adders are built by chaining slices: the carry-out of each slice drives the carry-in of the slice above it.

Top module: `csel_adder`

## Requirements
- R1: The concatenation {cout, sum} equals the (W+1)-bit value a + b + cin for every input.
- R2: The sum bits [1:0] equal the two low bits of a[1:0] + b[1:0] + cin, taken from a ripple path with no selection stage.
- R3: Inside each 16-bit slice, the groups start at bit positions 0, 2, 4, 7 and 11. A carry produced below any of these positions reaches the bit above it. For example, a = 2^k - 1, b = 0 and cin = 1 give sum = 2^k for every k < W.
- R4: With STYLE = 1 (incrementer candidate) and STYLE = 0 (second ripple candidate), the outputs are identical for the same inputs.
- R5: For widths 16, 32, 64 and 128, the carry-out of each 16-bit slice is the carry-in of the next slice. The result stays exact across bits 16, 32, 48 and every other slice seam.
- R6: Operands that are all ones with cin = 1 give sum all ones and cout = 1.
- R7: Zero operands give sum equal to cin in bit 0 and zero elsewhere, with cout = 0.
- R8: When b = ~a, the result is sum all ones and cout = 0 if cin = 0. It is sum = 0 and cout = 1 if cin = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W | First unsigned operand |
| b | input | W | Second unsigned operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | W | Low W bits of a + b + cin |
| cout | output | 1 | Carry selected by the topmost group |

## Verification
Two things can happen in the same evaluation: a selection carry arrives at a group's multiplexer, and that group's own carry-one candidate overflows. In that case the carry-out of the group has to come from the incremented word, not from the ripple adder. The bench provokes this with operands of the form 2^k - 1 plus a carry-in, and with b = ~a. Both push one carry through every group and slice seam. Each result is judged against a behavioural wide addition. The same vectors also run through the dual-ripple style and through 16-, 32- and 64-bit copies.

// File: rtl/csel_pkg.sv
// Shared constants and group-layout functions for the carry-select adder.
// Assumes groups numbered 0..G-1 inside a slice; group 0 is 2 bits wide,
// group g>0 is g+1 bits wide, so five groups fill a 16-bit slice.
package csel_pkg;

    localparam int STYLE_RIPPLE = 0;
    localparam int STYLE_INCR   = 1;

    // Width of group g within a slice.
    function automatic int grp_width(input int g);
        return (g == 0) ? 2 : g + 1;
    endfunction

    // Lowest bit position of group g within a slice.
    function automatic int grp_base(input int g);
        return (g == 0) ? 0 : 2 + ((g - 1) * (g + 2)) / 2;
    endfunction

    // Total bits covered by a slice of the given group count.
    function automatic int slice_width(input int groups);
        return grp_base(groups);
    endfunction

endpackage

// File: rtl/csel_ripple.sv
// Ripple-carry adder of WIDTH bits built from a chain of full adders.
// Assumes WIDTH >= 1. Purely combinational.
module csel_ripple #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             ci,
    output logic [WIDTH-1:0] s,
    output logic             co
);
    logic [WIDTH:0] c;

    assign c[0] = ci;

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_fa
            // One full-adder cell: sum and carry of bit i.
            assign s[i]   = x[i] ^ y[i] ^ c[i];
            assign c[i+1] = (x[i] & y[i]) | (c[i] & (x[i] ^ y[i]));
        end
    endgenerate

    assign co = c[WIDTH];

endmodule

// File: rtl/csel_excess1.sv
// Excess-one converter: outputs its input plus one, modulo 2^WIDTH.
// Bit 0 is inverted; bit i flips when all lower bits are one.
// Assumes WIDTH >= 2. Purely combinational.
module csel_excess1 #(
    parameter int WIDTH = 5
) (
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    // allones[i] is the AND of din[i-1:0]; allones[0] is 1.
    logic [WIDTH-1:0] allones;

    assign allones[0] = 1'b1;

    genvar i;
    generate
        for (i = 1; i < WIDTH; i++) begin : g_and
            // Running AND of the lower bits.
            assign allones[i] = allones[i-1] & din[i-1];
        end
        for (i = 0; i < WIDTH; i++) begin : g_flip
            // Toggle bit i when every lower bit is set.
            assign dout[i] = din[i] ^ allones[i];
        end
    endgenerate

endmodule

// File: rtl/csel_group.sv
// One upper carry-select group. It forms a carry-zero candidate with a
// ripple adder. It forms a carry-one candidate either with the excess-one
// converter (STYLE 1) or with a second ripple adder (STYLE 0). Then it picks
// one of the two with sel, the carry from the group below.
module csel_group #(
    parameter int WIDTH = 3,
    parameter int STYLE = csel_pkg::STYLE_INCR
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             sel,
    output logic [WIDTH-1:0] s,
    output logic             co
);
    logic [WIDTH-1:0] s_zero, s_one;
    logic             c_zero, c_one;

    csel_ripple #(.WIDTH(WIDTH)) u_zero (
        .x(x), .y(y), .ci(1'b0), .s(s_zero), .co(c_zero)
    );

    generate
        if (STYLE == csel_pkg::STYLE_INCR) begin : g_incr
            csel_excess1 #(.WIDTH(WIDTH + 1)) u_inc (
                .din ({c_zero, s_zero}),
                .dout({c_one, s_one})
            );
        end else begin : g_dual
            csel_ripple #(.WIDTH(WIDTH)) u_one (
                .x(x), .y(y), .ci(1'b1), .s(s_one), .co(c_one)
            );
        end
    endgenerate

    // Final selection of sum and carry by the incoming carry.
    always_comb begin
        if (sel) begin
            s  = s_one;
            co = c_one;
        end else begin
            s  = s_zero;
            co = c_zero;
        end
    end

endmodule

// File: rtl/csel_slice.sv
// A 16-bit (for GROUPS = 5) square-root carry-select slice. Group 0 is a
// plain ripple adder on ci. Each higher group selects on the carry chosen
// by the group below. Assumes GROUPS >= 2.
module csel_slice #(
    parameter int GROUPS = 5,
    parameter int STYLE  = csel_pkg::STYLE_INCR,
    localparam int SW    = csel_pkg::slice_width(GROUPS)
) (
    input  logic [SW-1:0] x,
    input  logic [SW-1:0] y,
    input  logic          ci,
    output logic [SW-1:0] s,
    output logic          co
);
    logic [GROUPS:0] gc;

    csel_ripple #(.WIDTH(csel_pkg::grp_width(0))) u_low (
        .x (x[1:0]),
        .y (y[1:0]),
        .ci(ci),
        .s (s[1:0]),
        .co(gc[1])
    );

    assign gc[0] = ci;

    genvar g;
    generate
        for (g = 1; g < GROUPS; g++) begin : g_grp
            localparam int GW = csel_pkg::grp_width(g);
            localparam int GB = csel_pkg::grp_base(g);
            csel_group #(.WIDTH(GW), .STYLE(STYLE)) u_grp (
                .x  (x[GB+GW-1:GB]),
                .y  (y[GB+GW-1:GB]),
                .sel(gc[g]),
                .s  (s[GB+GW-1:GB]),
                .co (gc[g+1])
            );
        end
    endgenerate

    assign co = gc[GROUPS];

endmodule

// File: rtl/csel_adder.sv
// Top: unsigned W-bit carry-select adder built by chaining slices. Each
// slice's carry-out feeds the next slice's carry-in. Assumes W is a multiple
// of the slice width (16 for GROUPS = 5). Purely combinational: no clock and
// no reset.
module csel_adder #(
    parameter int W      = 128,
    parameter int GROUPS = 5,
    parameter int STYLE  = csel_pkg::STYLE_INCR
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    localparam int SW     = csel_pkg::slice_width(GROUPS);
    localparam int NSLICE = W / SW;

    logic [NSLICE:0] sc;

    assign sc[0] = cin;

    genvar k;
    generate
        for (k = 0; k < NSLICE; k++) begin : g_slice
            csel_slice #(.GROUPS(GROUPS), .STYLE(STYLE)) u_slice (
                .x (a[k*SW+SW-1:k*SW]),
                .y (b[k*SW+SW-1:k*SW]),
                .ci(sc[k]),
                .s (sum[k*SW+SW-1:k*SW]),
                .co(sc[k+1])
            );
        end
    endgenerate

    assign cout = sc[NSLICE];

endmodule

// File: rtl/csel_adder_chk.sv
// Checker bound to csel_adder. It compares the outputs with a behavioural
// wide addition and with the corner-case results. It holds only immediate
// checks, because the block has no clock.
module csel_adder_chk #(
    parameter int W = 128
) (
    input logic [W-1:0] a,
    input logic [W-1:0] b,
    input logic         cin,
    input logic [W-1:0] sum,
    input logic         cout
);
    logic [W:0] want;
    logic [2:0] low_want;

    // Behavioural reference for the whole result and for the low group.
    always_comb begin
        want     = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        low_want = {1'b0, a[1:0]} + {1'b0, b[1:0]} + {2'b00, cin};
    end

    // Output checks against the reference and the corner cases.
    always_comb begin
        a_r1_full_sum: assert ({cout, sum} == want)
            else $error("R1 result mismatch");
        a_r2_low_group: assert (sum[1:0] == low_want[1:0])
            else $error("R2 low group mismatch");
        if (&a && &b && cin) begin
            a_r6_all_ones: assert (&sum && cout)
                else $error("R6 all-ones case wrong");
        end
        if (a == '0 && b == '0) begin
            a_r7_zero_ops: assert (sum == {{(W-1){1'b0}}, cin} && !cout)
                else $error("R7 zero case wrong");
        end
        if (b == ~a) begin
            a_r8_complement: assert (cin ? (sum == '0 && cout) : (&sum && !cout))
                else $error("R8 complement case wrong");
        end
    end

endmodule

bind csel_adder csel_adder_chk #(.W(W)) u_chk (
    .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout)
);

// File: tb/tb_csel_adder.sv
// Bench: drives one vector per clock into adders of four widths and both
// styles, and compares each result with a behavioural addition.
module tb_csel_adder;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [127:0] a, b;
    logic         cin;

    logic [127:0] s128, r128;
    logic [63:0]  s64;
    logic [31:0]  s32;
    logic [15:0]  s16;
    logic         c128, cr128, c64, c32, c16;

    int checks = 0;
    int fails  = 0;

    csel_adder #(.W(128), .STYLE(1)) dut (
        .a(a), .b(b), .cin(cin), .sum(s128), .cout(c128));
    csel_adder #(.W(128), .STYLE(0)) dut_dual (
        .a(a), .b(b), .cin(cin), .sum(r128), .cout(cr128));
    csel_adder #(.W(64)) dut64 (
        .a(a[63:0]), .b(b[63:0]), .cin(cin), .sum(s64), .cout(c64));
    csel_adder #(.W(32)) dut32 (
        .a(a[31:0]), .b(b[31:0]), .cin(cin), .sum(s32), .cout(c32));
    csel_adder #(.W(16)) dut16 (
        .a(a[15:0]), .b(b[15:0]), .cin(cin), .sum(s16), .cout(c16));

    // Compare one width's {cout,sum} with the masked reference sum.
    task automatic cmp(input int w, input logic [128:0] got, input string tag);
        logic [128:0] mask, want;
        mask = ({1'b0, {128{1'b1}}}) >> (128 - w);
        want = ({1'b0, a} & mask) + ({1'b0, b} & mask) + {128'd0, cin};
        checks++;
        if (got !== want) begin
            fails++;
            $display("FAIL %s w=%0d got=%h expected=%h", tag, w, got, want);
        end
    endtask

    // Apply one vector, wait half a clock, check every instance.
    task automatic apply(input logic [127:0] va, input logic [127:0] vb,
                         input logic vc, input string tag);
        @(posedge clk);
        a = va; b = vb; cin = vc;
        @(negedge clk);
        cmp(128, {c128, s128}, {tag, " R1"});
        cmp(64,  {65'd0, c64, s64}, {tag, " R5"});
        cmp(32,  {97'd0, c32, s32}, {tag, " R5"});
        cmp(16,  {113'd0, c16, s16}, {tag, " R5"});
        checks++;
        if ({cr128, r128} !== {c128, s128}) begin
            fails++;
            $display("FAIL R4 style mismatch got=%h expected=%h",
                     {cr128, r128}, {c128, s128});
        end
        checks++;
        if (s128[1:0] !== 2'(a[1:0] + b[1:0] + {1'b0, cin})) begin
            fails++;
            $display("FAIL R2 low group got=%h expected=%h", s128[1:0],
                     2'(a[1:0] + b[1:0] + {1'b0, cin}));
        end
    endtask

    initial begin
        a = '0; b = '0; cin = 1'b0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // R7: zero operands, both carry-in values.
        apply('0, '0, 1'b0, "R7 zero cin0");
        checks++;
        if (s128 !== '0 || c128 !== 1'b0) begin
            fails++;
            $display("FAIL R7 got=%h expected=0", {c128, s128});
        end
        apply('0, '0, 1'b1, "R7 zero cin1");
        checks++;
        if (s128 !== 128'd1 || c128 !== 1'b0) begin
            fails++;
            $display("FAIL R7 got=%h expected=1", {c128, s128});
        end
        // R6: all ones with carry-in one.
        apply('1, '1, 1'b1, "R6 all ones");
        checks++;
        if (s128 !== '1 || c128 !== 1'b1) begin
            fails++;
            $display("FAIL R6 got=%h expected=%h", {c128, s128}, {1'b1, {128{1'b1}}});
        end
        // R3/R5: carry crossing every bit position, group and slice seams.
        for (int k = 1; k < 128; k++) begin
            apply((128'd1 << k) - 128'd1, '0, 1'b1, "R3 carry cross");
            checks++;
            if (s128 !== (128'd1 << k) || c128 !== 1'b0) begin
                fails++;
                $display("FAIL R3 k=%0d got=%h expected=%h", k, {c128, s128},
                         {1'b0, 128'd1 << k});
            end
        end
        // R8: complement operands force a full propagate chain.
        for (int n = 0; n < 40; n++) begin
            logic [127:0] v;
            v = {$urandom, $urandom, $urandom, $urandom};
            apply(v, ~v, n[0], "R8 complement");
            checks++;
            if (c128 !== n[0] || s128 !== (n[0] ? 128'd0 : '1)) begin
                fails++;
                $display("FAIL R8 got=%h expected=%h", {c128, s128},
                         n[0] ? {1'b1, 128'd0} : {1'b0, {128{1'b1}}});
            end
        end
        // R1/R4/R5: random vectors.
        for (int n = 0; n < 3000; n++) begin
            apply({$urandom, $urandom, $urandom, $urandom},
                  {$urandom, $urandom, $urandom, $urandom},
                  1'($urandom), "R1 random");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired got=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule